// File: doc/BRIEF.md
# Branch and Return-Stack Control Unit

This block owns the program counter and the zero and carry flags of a small processor core. The PC counts long words and is 17 bits wide. Each cycle the core presents one decoded flow-control request. The block resolves it into a new PC, an optional register write and updates to its four-deep return stack. Targets below 0x200 run from the local register file. Targets at 0x200 or above run from shared hub memory, and the block reports which of the two the current PC selects.

The requests are a plain step, a jump that leaves a link word behind, a link-load that computes an address without branching, a call, a return, a swap-jump that trades the packed flags and PC with a register, and a jump conditioned on a sampled input pin. The result of a taken request is visible on the outputs one clock after it is presented.

Top module: `branch_unit`

## Requirements
- R1: After reset the PC is 0, both flags are 0, the return stack is empty, the underflow flag is 0 and the write-back enable is low.
- R2: While `opValid` is low the PC, the flags and the stack hold, and the write-back enable is low after the next edge.
- R3: A step request (`opKind`=0) moves the PC to PC+1 modulo 2^17.
- R4: A jump (`opKind`=1) loads the target. The target is `immAddr` when `relMode` is 0. When `relMode` is 1 it is PC+1 plus the sign-extended 9-bit `relOff` (-256..+255), taken modulo 2^17.
- R5: A jump writes the link word to register address 0x1EF on the write-back port. The link word is Z at bit 18, C at bit 17 and the old PC+1 at bits 16:0, with all higher bits zero.
- R6: A link-load (`opKind`=2) writes the target, zero-extended, to address 0x1EF and steps the PC by one without branching.
- R7: A call (`opKind`=3) pushes PC+1 and loads the target. A return (`opKind`=4) pops the most recent entry into the PC, in last-in-first-out order.
- R8: A call made while four entries are held discards the oldest entry.
- R9: A return on an empty stack loads PC 0 and sets the underflow flag, which stays set until reset.
- R10: A swap-jump (`opKind`=5) writes the link word built from the current Z, C and PC+1 to register `dstAddr`, and loads the PC from `srcVal[16:0]`. It loads Z from `srcVal[18]` only when `wrZ` is set, and C from `srcVal[17]` only when `wrC` is set.
- R11: `pins` is captured into a register on every edge. A pin jump (`opKind`=6) tests the captured bit `pinSel` and jumps when that bit is 1, or when it is 0 if `pinInvert` is set. Otherwise the PC steps by one.
- R12: `hubMode` is high exactly when the PC is 0x200 or above.
- R13: When `flagWe` is set on a valid request other than a swap-jump, Z and C take `flagZIn` and `flagCIn`. A link word built in the same cycle uses the old flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Request present this cycle |
| opKind | input | 3 | Request code (0 step, 1 jump, 2 link-load, 3 call, 4 return, 5 swap-jump, 6 pin jump) |
| relMode | input | 1 | Target is PC-relative |
| pinInvert | input | 1 | Pin jump is taken on a low pin |
| wrZ | input | 1 | Swap-jump restores Z |
| wrC | input | 1 | Swap-jump restores C |
| immAddr | input | 17 | Absolute target |
| relOff | input | 9 | Signed relative offset |
| srcVal | input | 19 | Swap-jump source in link-word format |
| dstAddr | input | 9 | Swap-jump destination register |
| pinSel | input | 6 | Pin index for the pin jump |
| pins | input | 64 | Input pin levels |
| flagWe | input | 1 | Flag update from the ALU |
| flagZIn | input | 1 | New Z value |
| flagCIn | input | 1 | New C value |
| pc | output | 17 | Current program counter |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry flag |
| hubMode | output | 1 | PC selects hub memory |
| underflow | output | 1 | Sticky return-stack underflow |
| wbEn | output | 1 | Register write valid |
| wbAddr | output | 9 | Register write address |
| wbData | output | 32 | Register write data |

## Verification
A corrupt stack entry or a wrong stack count does not show at the ports when it happens. It appears as a wrong PC one cycle after the return that reads it, which may be several requests later. The bench therefore runs call and return chains deep enough to overflow and then drain the stack. A flag or PC error appears within one cycle in the link word of the next jump or swap-jump, so each link-writing request also checks the state left by the requests before it. A pin-sampling error appears as a wrong taken or not-taken decision one cycle after the pins change.

// File: rtl/branch_pkg.sv
package branch_pkg;

  typedef enum logic [2:0] {
    OP_STEP = 3'd0,
    OP_JUMP = 3'd1,
    OP_LOC  = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_SWAP = 3'd5,
    OP_PINJ = 3'd6
  } opKind_t;

  typedef struct packed {
    logic takeTarget;
    logic takeSrc;
    logic takePop;
    logic step;
    logic push;
    logic pop;
    logic linkJmp;
    logic linkLoc;
    logic linkSwap;
    logic restZ;
    logic restC;
    logic aluFlags;
  } brStrobe_t;

endpackage

// File: rtl/branch_ctrl.sv
module branch_ctrl
  import branch_pkg::*;
(
  input  logic       opValid,
  input  logic [2:0] opKind,
  input  logic       pinInvert,
  input  logic       wrZ,
  input  logic       wrC,
  input  logic       flagWe,
  input  logic       pinHit,
  output brStrobe_t  st
);

  opKind_t kind;
  assign kind = opKind_t'(opKind);

  always_comb begin
    st = '0;
    if (opValid) begin
      st.aluFlags = flagWe && (kind != OP_SWAP);
      case (kind)
        OP_JUMP: begin
          st.takeTarget = 1'b1;
          st.linkJmp    = 1'b1;
        end
        OP_LOC: begin
          st.step    = 1'b1;
          st.linkLoc = 1'b1;
        end
        OP_CALL: begin
          st.takeTarget = 1'b1;
          st.push       = 1'b1;
        end
        OP_RET: begin
          st.takePop = 1'b1;
          st.pop     = 1'b1;
        end
        OP_SWAP: begin
          st.takeSrc  = 1'b1;
          st.linkSwap = 1'b1;
          st.restZ    = wrZ;
          st.restC    = wrC;
        end
        OP_PINJ: begin
          if (pinHit ^ pinInvert) st.takeTarget = 1'b1;
          else                    st.step       = 1'b1;
        end
        default: st.step = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/branch_dp.sv
module branch_dp
  import branch_pkg::*;
#(
  parameter int PC_W      = 17,
  parameter int OFF_W     = 9,
  parameter int DEPTH     = 4,
  parameter int NPINS     = 64,
  parameter int RADDR_W   = 9,
  parameter int DATA_W    = 32,
  parameter int LINK_ADDR = 'h1EF,
  parameter int HUB_BASE  = 'h200
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  brStrobe_t                st,
  input  logic                     relMode,
  input  logic [PC_W-1:0]          immAddr,
  input  logic [OFF_W-1:0]         relOff,
  input  logic [PC_W+1:0]          srcVal,
  input  logic [RADDR_W-1:0]       dstAddr,
  input  logic [$clog2(NPINS)-1:0] pinSel,
  input  logic [NPINS-1:0]         pins,
  input  logic                     flagZIn,
  input  logic                     flagCIn,
  output logic [PC_W-1:0]          pc,
  output logic                     flagZ,
  output logic                     flagC,
  output logic                     hubMode,
  output logic                     underflow,
  output logic                     wbEn,
  output logic [RADDR_W-1:0]       wbAddr,
  output logic [DATA_W-1:0]        wbData,
  output logic                     pinHit
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PC_W-1:0]   pcNext, target, stackTop;
  logic [PC_W-1:0]   stack [DEPTH];
  logic [CNT_W-1:0]  count;
  logic [NPINS-1:0]  pinReg;
  logic [DATA_W-1:0] linkWord, locWord;
  logic              empty;

  assign pcNext   = pc + 1'b1;
  assign target   = relMode ? pcNext + {{(PC_W-OFF_W){relOff[OFF_W-1]}}, relOff} : immAddr;
  assign empty    = (count == '0);
  assign stackTop = empty ? '0 : stack[0];
  assign pinHit   = pinReg[pinSel];
  assign hubMode  = (pc >= PC_W'(HUB_BASE));

  always_comb begin
    linkWord = '0;
    linkWord[PC_W-1:0] = pcNext;
    linkWord[PC_W]     = flagC;
    linkWord[PC_W+1]   = flagZ;
    locWord = '0;
    locWord[PC_W-1:0]  = target;
  end

  // PC, flags and pin sampling
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc        <= '0;
      flagZ     <= 1'b0;
      flagC     <= 1'b0;
      underflow <= 1'b0;
      pinReg    <= '0;
    end else begin
      pinReg <= pins;
      if (st.takeTarget)   pc <= target;
      else if (st.takeSrc) pc <= srcVal[PC_W-1:0];
      else if (st.takePop) pc <= stackTop;
      else if (st.step)    pc <= pcNext;
      if (st.restZ)         flagZ <= srcVal[PC_W+1];
      else if (st.aluFlags) flagZ <= flagZIn;
      if (st.restC)         flagC <= srcVal[PC_W];
      else if (st.aluFlags) flagC <= flagCIn;
      if (st.pop && empty) underflow <= 1'b1;
    end
  end

  // Register write-back port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbEn   <= 1'b0;
      wbAddr <= '0;
      wbData <= '0;
    end else begin
      wbEn <= st.linkJmp | st.linkLoc | st.linkSwap;
      if (st.linkJmp) begin
        wbAddr <= RADDR_W'(LINK_ADDR);
        wbData <= linkWord;
      end else if (st.linkLoc) begin
        wbAddr <= RADDR_W'(LINK_ADDR);
        wbData <= locWord;
      end else if (st.linkSwap) begin
        wbAddr <= dstAddr;
        wbData <= linkWord;
      end
    end
  end

  // Return stack: entry 0 is the most recent, a push shifts toward the oldest
  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (st.push) begin
      if (count != CNT_W'(DEPTH)) count <= count + 1'b1;
    end else if (st.pop) begin
      if (!empty) count <= count - 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stack[i] <= '0;
      end else if (st.push) begin
        if (i == 0) stack[i] <= pcNext;
        else        stack[i] <= stack[(i > 0) ? i-1 : 0];
      end else if (st.pop) begin
        if (i == DEPTH-1) stack[i] <= '0;
        else              stack[i] <= stack[(i < DEPTH-1) ? i+1 : i];
      end
    end
  end

endmodule

// File: rtl/branch_unit.sv
module branch_unit
  import branch_pkg::*;
#(
  parameter int PC_W      = 17,
  parameter int OFF_W     = 9,
  parameter int DEPTH     = 4,
  parameter int NPINS     = 64,
  parameter int RADDR_W   = 9,
  parameter int DATA_W    = 32,
  parameter int LINK_ADDR = 'h1EF,
  parameter int HUB_BASE  = 'h200,
  localparam int SEL_W    = $clog2(NPINS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               opValid,
  input  logic [2:0]         opKind,
  input  logic               relMode,
  input  logic               pinInvert,
  input  logic               wrZ,
  input  logic               wrC,
  input  logic [PC_W-1:0]    immAddr,
  input  logic [OFF_W-1:0]   relOff,
  input  logic [PC_W+1:0]    srcVal,
  input  logic [RADDR_W-1:0] dstAddr,
  input  logic [SEL_W-1:0]   pinSel,
  input  logic [NPINS-1:0]   pins,
  input  logic               flagWe,
  input  logic               flagZIn,
  input  logic               flagCIn,
  output logic [PC_W-1:0]    pc,
  output logic               flagZ,
  output logic               flagC,
  output logic               hubMode,
  output logic               underflow,
  output logic               wbEn,
  output logic [RADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0]  wbData
);

  brStrobe_t st;
  logic      pinHit;

  branch_ctrl u_ctrl (
    .opValid  (opValid),
    .opKind   (opKind),
    .pinInvert(pinInvert),
    .wrZ      (wrZ),
    .wrC      (wrC),
    .flagWe   (flagWe),
    .pinHit   (pinHit),
    .st       (st)
  );

  branch_dp #(
    .PC_W(PC_W), .OFF_W(OFF_W), .DEPTH(DEPTH), .NPINS(NPINS),
    .RADDR_W(RADDR_W), .DATA_W(DATA_W), .LINK_ADDR(LINK_ADDR), .HUB_BASE(HUB_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st),
    .relMode(relMode), .immAddr(immAddr), .relOff(relOff),
    .srcVal(srcVal), .dstAddr(dstAddr), .pinSel(pinSel), .pins(pins),
    .flagZIn(flagZIn), .flagCIn(flagCIn),
    .pc(pc), .flagZ(flagZ), .flagC(flagC), .hubMode(hubMode),
    .underflow(underflow), .wbEn(wbEn), .wbAddr(wbAddr), .wbData(wbData),
    .pinHit(pinHit)
  );

endmodule

module branch_unit_chk #(
  parameter int PC_W      = 17,
  parameter int RADDR_W   = 9,
  parameter int DATA_W    = 32,
  parameter int LINK_ADDR = 'h1EF
) (
  input logic               clk,
  input logic               rstN,
  input logic               opValid,
  input logic [2:0]         opKind,
  input logic               relMode,
  input logic               wrZ,
  input logic [PC_W-1:0]    immAddr,
  input logic [PC_W-1:0]    pc,
  input logic               flagZ,
  input logic               underflow,
  input logic               wbEn,
  input logic [RADDR_W-1:0] wbAddr,
  input logic [DATA_W-1:0]  wbData
);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(pc) && !wbEn);

  // R5
  jump_link_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind == 3'd1) |=>
      wbEn && wbAddr == RADDR_W'(LINK_ADDR) && wbData[PC_W-1:0] == $past(pc) + 1'b1);

  // R6
  loc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind == 3'd2) |=> pc == $past(pc) + 1'b1 && wbAddr == RADDR_W'(LINK_ADDR));

  // R7
  call_abs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind == 3'd3 && !relMode) |=> pc == $past(immAddr));

  // R9
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> underflow);

  // R10
  swap_keep_z_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind == 3'd5 && !wrZ) |=> flagZ == $past(flagZ));

endmodule

bind branch_unit branch_unit_chk #(
  .PC_W(PC_W), .RADDR_W(RADDR_W), .DATA_W(DATA_W), .LINK_ADDR(LINK_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind), .relMode(relMode),
  .wrZ(wrZ), .immAddr(immAddr), .pc(pc), .flagZ(flagZ), .underflow(underflow),
  .wbEn(wbEn), .wbAddr(wbAddr), .wbData(wbData)
);

// File: tb/tb_branch_unit.sv
`timescale 1ns/1ps
module tb_branch_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opKind = '0;
  logic        relMode = 1'b0, pinInvert = 1'b0, wrZ = 1'b0, wrC = 1'b0;
  logic [16:0] immAddr = '0;
  logic [8:0]  relOff = '0;
  logic [18:0] srcVal = '0;
  logic [8:0]  dstAddr = '0;
  logic [5:0]  pinSel = '0;
  logic [63:0] pins = '0;
  logic        flagWe = 1'b0, flagZIn = 1'b0, flagCIn = 1'b0;
  logic [16:0] pc;
  logic        flagZ, flagC, hubMode, underflow, wbEn;
  logic [8:0]  wbAddr;
  logic [31:0] wbData;

  always #5 clk = ~clk;

  branch_unit dut (.*);

  typedef struct {
    logic [16:0] pc;
    logic        z, c, uf, hub, we;
    logic [8:0]  addr;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          nChecks = 0, nFails = 0;
  logic [16:0] mPc = '0;
  logic        mZ = 0, mC = 0, mUf = 0;
  logic [63:0] mPinReg = '0;
  logic [63:0] pinsDrive = '0;
  logic [16:0] mStk[$];

  // Monitor: compare one expected item per cycle, away from the edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      nChecks++;
      if (pc !== e.pc || flagZ !== e.z || flagC !== e.c || underflow !== e.uf ||
          hubMode !== e.hub || wbEn !== e.we ||
          (e.we && (wbAddr !== e.addr || wbData !== e.data))) begin
        nFails++;
        $display("FAIL %s: got pc=%h z=%b c=%b uf=%b hub=%b we=%b addr=%h data=%h exp pc=%h z=%b c=%b uf=%b hub=%b we=%b addr=%h data=%h",
                 e.tag, pc, flagZ, flagC, underflow, hubMode, wbEn, wbAddr, wbData,
                 e.pc, e.z, e.c, e.uf, e.hub, e.we, e.addr, e.data);
      end
    end
  end

  function automatic logic [31:0] link(logic z, logic c, logic [16:0] p);
    return {13'd0, z, c, p};
  endfunction

  task automatic doOp(input logic v, input logic [2:0] k, input logic rel, input logic inv,
                      input logic wz, input logic wc, input logic [16:0] imm,
                      input logic [8:0] off, input logic [18:0] src, input logic [8:0] dst,
                      input logic [5:0] sel, input logic fwe, input logic fz, input logic fc,
                      input string tag);
    exp_t e;
    logic [16:0] pcN, tgt;
    @(negedge clk);
    opValid = v; opKind = k; relMode = rel; pinInvert = inv; wrZ = wz; wrC = wc;
    immAddr = imm; relOff = off; srcVal = src; dstAddr = dst; pinSel = sel;
    flagWe = fwe; flagZIn = fz; flagCIn = fc; pins = pinsDrive;
    pcN = mPc + 17'd1;
    tgt = rel ? pcN + {{8{off[8]}}, off} : imm;
    e.we = 0; e.addr = '0; e.data = '0; e.tag = tag;
    if (v) begin
      case (k)
        3'd1: begin e.we = 1; e.addr = 9'h1EF; e.data = link(mZ, mC, pcN); mPc = tgt; end
        3'd2: begin e.we = 1; e.addr = 9'h1EF; e.data = {15'd0, tgt}; mPc = pcN; end
        3'd3: begin mStk.push_front(pcN); if (mStk.size() > 4) void'(mStk.pop_back()); mPc = tgt; end
        3'd4: begin
          if (mStk.size() == 0) begin mPc = '0; mUf = 1; end
          else mPc = mStk.pop_front();
        end
        3'd5: begin
          e.we = 1; e.addr = dst; e.data = link(mZ, mC, pcN); mPc = src[16:0];
          if (wz) mZ = src[18];
          if (wc) mC = src[17];
        end
        3'd6: mPc = (mPinReg[sel] ^ inv) ? tgt : pcN;
        default: mPc = pcN;
      endcase
      if (fwe && k != 3'd5) begin mZ = fz; mC = fc; end
    end
    mPinReg = pinsDrive;
    e.pc = mPc; e.z = mZ; e.c = mC; e.uf = mUf; e.hub = (mPc >= 17'h200);
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    doOp(0, 0, 0, 0, 0, 0, '0, '0, '0, '0, '0, 0, 0, 0, tag);
  endtask
  task automatic jmp(input logic rel, input logic [16:0] imm, input logic [8:0] off, input string tag);
    doOp(1, 3'd1, rel, 0, 0, 0, imm, off, '0, '0, '0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    nChecks++;
    if (pc !== 0 || flagZ !== 0 || flagC !== 0 || underflow !== 0 || wbEn !== 0 || hubMode !== 0) begin
      nFails++;
      $display("FAIL R1 reset: got pc=%h z=%b c=%b uf=%b we=%b exp all zero", pc, flagZ, flagC, underflow, wbEn);
    end
    idle("R2 idle hold");
    doOp(1, 3'd0, 0, 0, 0, 0, '0, '0, '0, '0, '0, 0, 0, 0, "R3 step");
    doOp(1, 3'd0, 0, 0, 0, 0, '0, '0, '0, '0, '0, 1, 1, 0, "R13 alu flags on step");
    jmp(0, 17'h1FFFF, '0, "R4 R5 abs jump to top with link");
    doOp(1, 3'd0, 0, 0, 0, 0, '0, '0, '0, '0, '0, 0, 0, 0, "R3 step wraps to 0");
    idle("R2 idle after wrap");
    jmp(1, '0, 9'h1FF, "R4 rel jump offset -1");
    jmp(0, 17'h1FF80, '0, "R5 link word near top");
    jmp(1, '0, 9'h0FF, "R4 rel jump +255 wraps");
    jmp(0, 17'h00200, '0, "R12 hub at 0x200");
    jmp(0, 17'h001FF, '0, "R12 local at 0x1FF");
    doOp(1, 3'd1, 1, 0, 0, 0, '0, 9'h100, '0, '0, '0, 1, 0, 1, "R13 jump link uses old flags");
    doOp(1, 3'd2, 1, 0, 0, 0, '0, 9'h010, '0, '0, '0, 0, 0, 0, "R6 rel link-load no branch");
    doOp(1, 3'd2, 0, 0, 0, 0, 17'h12345, '0, '0, '0, '0, 0, 0, 0, "R6 abs link-load");
    for (int i = 0; i < 5; i++)
      doOp(1, 3'd3, 0, 0, 0, 0, 17'(17'h00400 + 17'(i) * 17'h100), '0, '0, '0, '0, 0, 0, 0, "R7 R8 call chain");
    for (int i = 0; i < 4; i++)
      doOp(1, 3'd4, 0, 0, 0, 0, '0, '0, '0, '0, '0, 0, 0, 0, "R7 R8 lifo return");
    doOp(1, 3'd4, 0, 0, 0, 0, '0, '0, '0, '0, '0, 0, 0, 0, "R9 return on empty");
    doOp(1, 3'd0, 0, 0, 0, 0, '0, '0, '0, '0, '0, 0, 0, 0, "R9 underflow sticky");
    doOp(1, 3'd3, 1, 0, 0, 0, '0, 9'h020, '0, '0, '0, 0, 0, 0, "R7 rel call");
    doOp(1, 3'd4, 0, 0, 0, 0, '0, '0, '0, '0, '0, 0, 0, 0, "R7 return after rel call");
    doOp(1, 3'd5, 0, 0, 1, 0, '0, '0, {1'b1, 1'b1, 17'h00777}, 9'h033, '0, 0, 0, 0, "R10 swap restores Z only");
    doOp(1, 3'd5, 0, 0, 0, 1, '0, '0, {1'b0, 1'b0, 17'h00300}, 9'h044, '0, 0, 0, 0, "R10 swap restores C only");
    doOp(1, 3'd5, 0, 0, 0, 0, '0, '0, {1'b0, 1'b1, 17'h00500}, 9'h055, '0, 1, 1, 1, "R10 R13 swap ignores alu flags");
    pinsDrive = 64'h20;
    doOp(1, 3'd6, 0, 0, 0, 0, 17'h00900, '0, '0, '0, 6'd5, 0, 0, 0, "R11 pin not yet sampled");
    doOp(1, 3'd6, 0, 0, 0, 0, 17'h00A00, '0, '0, '0, 6'd5, 0, 0, 0, "R11 pin high taken");
    doOp(1, 3'd6, 0, 1, 0, 0, 17'h00B00, '0, '0, '0, 6'd5, 0, 0, 0, "R11 inverted not taken");
    doOp(1, 3'd6, 1, 1, 0, 0, '0, 9'h005, '0, '0, 6'd4, 0, 0, 0, "R11 inverted low pin taken rel");
    pinsDrive = 64'h0;
    doOp(1, 3'd6, 0, 0, 0, 0, 17'h00C00, '0, '0, '0, 6'd5, 0, 0, 0, "R11 pin still sampled high");
    doOp(1, 3'd6, 0, 0, 0, 0, 17'h00D00, '0, '0, '0, 6'd5, 0, 0, 0, "R11 pin low not taken");
    idle("R2 final idle");
    repeat (3) @(posedge clk);
    #2;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule